// File: doc/BRIEF.md
# Vectorised Condition Result Bit Packer

This unit takes a stream of single-bit condition results, one per vector element, and packs them into words for an integer register file. Each incoming item carries its element index, the result bit, a flag saying predication skipped the element, and a flag marking the final element of the vector. Upstream logic reduces four gated condition bits to one bit per element. Neither that reduction nor the register file belongs to this block.

A 2-bit density control sets how many results share one destination element: 1, 2, 4 or 8. The condition side's element-width field supplies this control, not the integer side. Results fill each destination element from the least significant bit upward, and every bit above them is zero. A separate 2-bit control sets the integer element width, and bits at or above that width are also cleared. In scalar mode every result goes into one register, with result i at bit i. The write port carries a register offset, the data and a last flag, under a valid/ready handshake. The result input uses a valid/ready handshake of its own.

Top module: `crbit_packer`

## Requirements
- R1: Density code 00, 01, 10 or 11 on `cfg_dens` packs k = 1, 2, 4 or 8 results into each destination element.
- R2: Outside scalar mode, the result of element i is written to register offset i / k, which is i shifted right by the density code.
- R3: Outside scalar mode, the result of element i sits at bit (i mod k) of its destination word, with bit 0 the least significant.
- R4: Outside scalar mode, all bits of a written word at position k and above are zero.
- R5: With `cfg_scalar` high, every write goes to offset 0, result i sits at bit i, and exactly one write is issued when the last element is accepted.
- R6: `cfg_ewid` code 00, 01, 10 or 11 sets the integer element width to 8, 16, 32 or 64 bits. Every written bit at or above that width is zero, whatever the density.
- R7: An element with `in_skip` high adds a zero at its position, but its bit position is still used, so later elements keep their positions.
- R8: A write is issued when an element fills the last position of its group (bit k-1) or carries `in_last`. `wr_last` is high only on the write produced by the last element. No write is issued for any other element.
- R9: While `wr_valid` is high and `wr_ready` is low, the offset, data and last flag hold steady and `in_ready` is low.
- R10: After reset, `wr_valid` is low and `in_ready` is high, and the first group begins empty.
- R11: The write for a group is valid in the clock cycle after its completing element is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_dens | input | 2 | Packing density code (k = 1 << code) |
| cfg_scalar | input | 1 | Scalar destination mode |
| cfg_ewid | input | 2 | Integer element width code (8 << code bits) |
| in_valid | input | 1 | Result item valid |
| in_ready | output | 1 | Unit can accept a result item |
| in_idx | input | IDXW | Element index of the item |
| in_bit | input | 1 | Condition result bit |
| in_skip | input | 1 | Element masked out by predication |
| in_last | input | 1 | Final element of the vector |
| wr_valid | output | 1 | Register write valid |
| wr_ready | input | 1 | Register file accepts the write |
| wr_off | output | IDXW | Destination register offset |
| wr_data | output | XLEN | Packed write data |
| wr_last | output | 1 | Write closes the vector |

## Verification
The completing element of a group is accepted on a clock edge, and its write appears on the port one register later. The bench samples `wr_valid` at the falling edge right after each acceptance. There it expects the write exactly when the element ended a group, and no write otherwise. A queue holds the expected writes. The monitor compares each write at the falling edge before the rising edge on which `wr_valid` and `wr_ready` both hold, so each write is checked once, in order. During backpressure the monitor compares successive falling-edge samples to confirm the write holds steady.

// File: rtl/crpack_pkg.sv
package crpack_pkg;
  // Packing density: results per destination element is 1 << code.
  typedef enum logic [1:0] {DENS_1 = 2'b00, DENS_2 = 2'b01, DENS_4 = 2'b10, DENS_8 = 2'b11} dens_e;
  // Integer element width: 8 << code bits.
  typedef enum logic [1:0] {EW_8 = 2'b00, EW_16 = 2'b01, EW_32 = 2'b10, EW_64 = 2'b11} ewid_e;
endpackage

// File: rtl/crpack_pos.sv
module crpack_pos
  import crpack_pkg::*;
#(
  parameter int IDXW = 6
) (
  input  logic [IDXW-1:0] idx,
  input  dens_e           dens,
  input  logic            scalar,
  input  logic            last,
  output logic [IDXW-1:0] off,
  output logic [IDXW-1:0] pos,
  output logic            grp_end
);
  logic [IDXW-1:0] lane_max;

  always_comb begin
    lane_max = IDXW'((32'd1 << dens) - 32'd1);
    if (scalar) begin
      off = '0;
      pos = idx;
    end else begin
      off = idx >> dens;
      pos = idx & lane_max;
    end
    grp_end = last | (~scalar & (pos == lane_max));
  end
endmodule

// File: rtl/crpack_accum.sv
module crpack_accum #(
  parameter int XLEN = 64,
  parameter int IDXW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            bit_in,
  input  logic            skip,
  input  logic [IDXW-1:0] pos,
  input  logic            grp_end,
  output logic [XLEN-1:0] merged
);
  logic [XLEN-1:0] acc_q, acc_d, base;
  logic            eff_bit;

  always_comb begin
    eff_bit = bit_in & ~skip;
    // Position zero opens a new destination word: old partial bits are dropped.
    base    = (pos == '0) ? '0 : acc_q;
    merged  = base | (XLEN'(eff_bit) << pos);
    acc_d   = acc_q;
    if (take) acc_d = grp_end ? '0 : merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/crpack_wrport.sv
module crpack_wrport #(
  parameter int XLEN = 64,
  parameter int IDXW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [IDXW-1:0] ld_off,
  input  logic [XLEN-1:0] ld_data,
  input  logic            ld_last,
  input  logic            wr_ready,
  output logic            room,
  output logic            wr_valid,
  output logic [IDXW-1:0] wr_off,
  output logic [XLEN-1:0] wr_data,
  output logic            wr_last
);
  logic            vld_d;
  logic [IDXW-1:0] off_d;
  logic [XLEN-1:0] data_d;
  logic            last_d;

  always_comb begin
    room   = ~wr_valid | wr_ready;
    vld_d  = wr_valid & ~wr_ready;
    off_d  = wr_off;
    data_d = wr_data;
    last_d = wr_last;
    if (load) begin
      vld_d  = 1'b1;
      off_d  = ld_off;
      data_d = ld_data;
      last_d = ld_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_off   <= '0;
      wr_data  <= '0;
      wr_last  <= 1'b0;
    end else begin
      wr_valid <= vld_d;
      if (load) begin
        wr_off  <= off_d;
        wr_data <= data_d;
        wr_last <= last_d;
      end
    end
  end
endmodule

// File: rtl/crbit_packer.sv
module crbit_packer
  import crpack_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IDXW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfg_dens,
  input  logic            cfg_scalar,
  input  logic [1:0]      cfg_ewid,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IDXW-1:0] in_idx,
  input  logic            in_bit,
  input  logic            in_skip,
  input  logic            in_last,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [IDXW-1:0] wr_off,
  output logic [XLEN-1:0] wr_data,
  output logic            wr_last
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [IDXW-1:0] e_off, e_pos;
  logic            e_end;
  logic            room, take;
  logic [XLEN-1:0] merged, ew_mask;
  int              ew_lim;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  crpack_pos #(.IDXW(IDXW)) u_pos (
    .idx     (in_idx),
    .dens    (dens_e'(cfg_dens)),
    .scalar  (cfg_scalar),
    .last    (in_last),
    .off     (e_off),
    .pos     (e_pos),
    .grp_end (e_end)
  );

  assign in_ready = rst_int_n & room;
  assign take     = in_valid & in_ready;

  crpack_accum #(.XLEN(XLEN), .IDXW(IDXW)) u_acc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .take    (take),
    .bit_in  (in_bit),
    .skip    (in_skip),
    .pos     (e_pos),
    .grp_end (e_end),
    .merged  (merged)
  );

  always_comb begin
    ew_lim = 8 << cfg_ewid;
    for (int b = 0; b < XLEN; b++) ew_mask[b] = (b < ew_lim);
  end

  crpack_wrport #(.XLEN(XLEN), .IDXW(IDXW)) u_wr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (take & e_end),
    .ld_off   (e_off),
    .ld_data  (merged & ew_mask),
    .ld_last  (in_last),
    .wr_ready (wr_ready),
    .room     (room),
    .wr_valid (wr_valid),
    .wr_off   (wr_off),
    .wr_data  (wr_data),
    .wr_last  (wr_last)
  );
endmodule

// File: rtl/crbit_packer_chk.sv
module crbit_packer_chk #(
  parameter int XLEN = 64,
  parameter int IDXW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      cfg_dens,
  input logic            cfg_scalar,
  input logic [1:0]      cfg_ewid,
  input logic            in_valid,
  input logic            in_ready,
  input logic            in_last,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic [IDXW-1:0] wr_off,
  input logic [XLEN-1:0] wr_data,
  input logic            wr_last
);
  logic [1:0] rec_dens, rec_ew;
  logic       rec_scalar;

  // Controls seen with the most recently accepted element.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_dens   <= 2'b00;
      rec_ew     <= 2'b11;
      rec_scalar <= 1'b0;
    end else if (in_valid && in_ready) begin
      rec_dens   <= cfg_dens;
      rec_ew     <= cfg_ewid;
      rec_scalar <= cfg_scalar;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_off) && $stable(wr_last));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |-> !in_ready);

  p_last_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last |=> wr_valid && wr_last);

  p_scalar_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && rec_scalar |-> wr_off == '0);

  p_density_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !rec_scalar |-> (wr_data >> (32'd1 << rec_dens)) == '0);

  p_ewid_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data >> (32'd8 << rec_ew)) == '0);
endmodule

bind crbit_packer crbit_packer_chk #(.XLEN(XLEN), .IDXW(IDXW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .cfg_dens   (cfg_dens),
  .cfg_scalar (cfg_scalar),
  .cfg_ewid   (cfg_ewid),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_last    (in_last),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_off     (wr_off),
  .wr_data    (wr_data),
  .wr_last    (wr_last)
);

// File: tb/crbit_packer_tb_top.sv
module crbit_packer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;
  localparam int IDXW = 6;

  logic            clk;
  logic            rst_n;
  logic [1:0]      cfg_dens;
  logic            cfg_scalar;
  logic [1:0]      cfg_ewid;
  logic            in_valid;
  logic            in_ready;
  logic [IDXW-1:0] in_idx;
  logic            in_bit;
  logic            in_skip;
  logic            in_last;
  logic            wr_valid;
  logic            wr_ready;
  logic [IDXW-1:0] wr_off;
  logic [XLEN-1:0] wr_data;
  logic            wr_last;

  int checks = 0;
  int errors = 0;
  logic bp_on = 1'b0;
  int   bp_cnt = 0;

  logic [IDXW-1:0] q_off[$];
  logic [XLEN-1:0] q_data[$];
  logic            q_last[$];
  string           q_tag[$];

  crbit_packer #(.XLEN(XLEN), .IDXW(IDXW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_dens(cfg_dens), .cfg_scalar(cfg_scalar),
    .cfg_ewid(cfg_ewid), .in_valid(in_valid), .in_ready(in_ready), .in_idx(in_idx),
    .in_bit(in_bit), .in_skip(in_skip), .in_last(in_last), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_off(wr_off), .wr_data(wr_data), .wr_last(wr_last)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Write-port backpressure pattern, changed only at falling edges.
  always @(negedge clk) begin
    bp_cnt   <= bp_cnt + 1;
    wr_ready <= bp_on ? (bp_cnt % 3 != 0) : 1'b1;
  end

  task automatic check(input bit ok, input string what, input logic [XLEN-1:0] got,
                       input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", what, got, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] ew_mask(input logic [1:0] ew);
    logic [XLEN-1:0] m;
    for (int b = 0; b < XLEN; b++) m[b] = (b < (8 << ew));
    return m;
  endfunction

  // Scoreboard monitor: compare each write on the cycle it is accepted.
  initial begin
    logic            prev_stall;
    logic [XLEN-1:0] prev_data;
    logic [IDXW-1:0] prev_off;
    prev_stall = 1'b0;
    prev_data  = '0;
    prev_off   = '0;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && wr_valid && prev_stall) begin
        check(wr_data == prev_data && wr_off == prev_off, "R9 write held under backpressure",
              wr_data, prev_data);
      end
      prev_stall = 1'b0;
      if (rst_n && wr_valid && !wr_ready) begin
        check(in_ready == 1'b0, "R9 in_ready low while write stalled", XLEN'(in_ready), '0);
        prev_stall = 1'b1;
        prev_data  = wr_data;
        prev_off   = wr_off;
      end
      if (rst_n && wr_valid && wr_ready) begin
        if (q_data.size() == 0) begin
          check(1'b0, "R8 unexpected write", wr_data, '0);
        end else begin
          string           t;
          logic [IDXW-1:0] eo;
          logic [XLEN-1:0] ed;
          logic            el;
          t  = q_tag.pop_front();
          eo = q_off.pop_front();
          ed = q_data.pop_front();
          el = q_last.pop_front();
          check(wr_off == eo, {t, " offset"}, XLEN'(wr_off), XLEN'(eo));
          check(wr_data == ed, {t, " data"}, wr_data, ed);
          check(wr_last == el, "R8 last flag", XLEN'(wr_last), XLEN'(el));
        end
      end
    end
  end

  task automatic run_vec(input string tag, input logic [1:0] dens, input logic scal,
                         input logic [1:0] ew, input int n, input logic [63:0] bits,
                         input logic [63:0] skips, input logic bp);
    logic [XLEN-1:0] acc;
    int k;
    // Let the previous vector drain completely.
    while (q_data.size() != 0 || wr_valid) @(negedge clk);
    @(negedge clk);
    cfg_dens = dens; cfg_scalar = scal; cfg_ewid = ew; bp_on = bp;
    k = 1 << dens;
    acc = '0;
    for (int i = 0; i < n; i++) begin
      int  pos;
      int  off;
      bit  fin;
      pos = scal ? i : (i % k);
      off = scal ? 0 : (i / k);
      if (pos == 0) acc = '0;
      if (pos < XLEN) acc[pos] = bits[i] & ~skips[i];
      fin = (i == n - 1) || (!scal && pos == k - 1);
      if (fin) begin
        q_tag.push_back(tag);
        q_off.push_back(IDXW'(off));
        q_data.push_back(acc & ew_mask(ew));
        q_last.push_back(i == n - 1);
        acc = '0;
      end
    end
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      bit ok;
      bit fin;
      int pos;
      pos = scal ? i : (i % k);
      fin = (i == n - 1) || (!scal && pos == k - 1);
      in_valid = 1'b1;
      in_idx   = IDXW'(i);
      in_bit   = bits[i];
      in_skip  = skips[i];
      in_last  = (i == n - 1);
      do begin
        #1;
        ok = in_ready;
        @(posedge clk);
        if (!ok) @(negedge clk);
      end while (!ok);
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      // R11: write appears one cycle after the completing element; R8: none otherwise.
      check(wr_valid == fin, fin ? "R11 write one cycle after group end" : "R8 no write mid-group",
            XLEN'(wr_valid), XLEN'(fin));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_dens = 2'b00; cfg_scalar = 1'b0; cfg_ewid = 2'b11;
    in_valid = 1'b0; in_idx = '0; in_bit = 1'b0; in_skip = 1'b0; in_last = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(wr_valid == 1'b0, "R10 wr_valid low after reset", XLEN'(wr_valid), '0);
    check(in_ready == 1'b1, "R10 in_ready high after reset", XLEN'(in_ready), 64'd1);

    run_vec("R1 density 1",        2'b00, 1'b0, 2'b11, 5,  64'b10110, 64'd0, 1'b0);
    run_vec("R2 density 2",        2'b01, 1'b0, 2'b11, 7,  64'b1101101, 64'd0, 1'b0);
    run_vec("R3 density 4",        2'b10, 1'b0, 2'b11, 9,  64'b101100111, 64'd0, 1'b0);
    run_vec("R4 density 8",        2'b11, 1'b0, 2'b11, 16, 64'hB5E3, 64'd0, 1'b1);
    run_vec("R5 scalar",           2'b00, 1'b1, 2'b11, 20, 64'hA5C3F, 64'd0, 1'b0);
    run_vec("R6 scalar width 8",   2'b10, 1'b1, 2'b00, 20, 64'hFFFFF, 64'd0, 1'b0);
    run_vec("R6 density 8 w8",     2'b11, 1'b0, 2'b00, 8,  64'hC9, 64'd0, 1'b1);
    run_vec("R7 skipped elements", 2'b10, 1'b0, 2'b11, 8,  64'hFF, 64'h5A, 1'b0);
    run_vec("R9 backpressure",     2'b01, 1'b0, 2'b01, 12, 64'hE6B, 64'd0, 1'b1);
    run_vec("R8 partial group",    2'b11, 1'b0, 2'b11, 3,  64'b101, 64'd0, 1'b1);

    while (q_data.size() != 0 || wr_valid) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule